// File: doc/BRIEF.md
# Saturating Doubling Multiply-Accumulate (Long)

This block is a lane-parallel datapath for signed fixed-point arithmetic. Each lane takes two narrow signed operands of `SRC_W` bits (16 or 32). It forms their product at twice that width and doubles it. The doubled product is then added to, or subtracted from, a double-width signed accumulator lane. Saturation is applied at two points. The first is a fixed set of extreme operand pairs, which force the doubled product to the largest positive wide value. The second is a sign-based overflow test on the wide add or subtract, which clamps the result to the wide extremes.

A single `op_sub` input picks add or subtract for every lane of an operation. The caller raises `issue` for one cycle with the operands present. The new accumulator vector appears on `acc_out` on the following cycle and holds until the next issue. Every saturation event in any lane sets `sat_flag`. This flag is sticky and clears only on reset.

Top module: `sqdmal_top`

## Requirements
- R1: With no forced operand pair, the doubled product of lane operands a and b is 2*a*b, computed exactly at 2*SRC_W bits.
- R2: When both operands of a lane are the most negative narrow value (-2^(SRC_W-1)), the doubled product is forced to 2^(2*SRC_W-1)-1 and the lane reports a saturation event.
- R3: The same forcing and event apply when one operand is -2^(SRC_W-1) and the other is -2^(SRC_W-2), in either order.
- R4: With `op_sub`=0 (add) and no overflow, the lane result is the accumulator plus the doubled product, with two's-complement wrap-free arithmetic.
- R5: On add overflow the result is set to a wide extreme and an event is reported. Overflow means the accumulator and the addend share a sign and the sum's sign differs from it. The extreme is 2^(2*SRC_W-1)-1 if the accumulator was non-negative and -2^(2*SRC_W-1) if it was negative.
- R6: With `op_sub`=1 the lane result is the accumulator minus the doubled product. Overflow is judged against the sign of the negated product and saturates as in R5.
- R7: Lanes are independent. Lane i reads `src_a`/`src_b` bits [i*SRC_W +: SRC_W] and `acc_in` bits [i*2*SRC_W +: 2*SRC_W]. It writes `acc_out` at that same accumulator position.
- R8: `sat_flag` becomes 1 in the cycle after an issue in which any lane reported an event. Once set, it stays 1 until reset.
- R9: `acc_out` and `sat_flag` change only in the cycle after `issue`=1 is sampled. While `issue` is 0 they hold.
- R10: A synchronous reset (`rst_n`=0 at a clock edge) clears `acc_out` to zero and `sat_flag` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | Start an operation on the current operands |
| op_sub | input | 1 | 0 = accumulate add, 1 = accumulate subtract |
| src_a | input | LANES*SRC_W | First narrow operand vector |
| src_b | input | LANES*SRC_W | Second narrow operand vector |
| acc_in | input | LANES*2*SRC_W | Wide accumulator vector |
| acc_out | output | LANES*2*SRC_W | New accumulator vector, registered |
| sat_flag | output | 1 | Sticky saturation indicator |

## Verification
The hardest situations to reach are the three forced operand pairs (R2, R3) and overflow of the wide accumulate (R5, R6). Uniform random operands almost never land on the exact extreme values, and they rarely push a wide accumulator past its range. The stimulus therefore draws each operand and accumulator lane from a biased pool: the most negative value, its half, the largest positive value and the wide extremes are over-represented among fully random values. Directed vectors add explicit overflow cases for both signs and both operations. A reset in mid-run lets the bench observe the sticky flag from a clean state.

// File: rtl/sqdmal_pkg.sv
// Package: shared operation encoding for the saturating doubling
// multiply-accumulate datapath.
package sqdmal_pkg;
    typedef enum logic {
        ACC_ADD = 1'b0,
        ACC_SUB = 1'b1
    } acc_op_e;
endpackage

// File: rtl/sqdmal_dbl_mul.sv
// Module: sqdmal_dbl_mul
// Forms the doubled signed product of two narrow operands at twice their
// width. Three extreme operand pairs (min*min, min*half, half*min) are
// forced to the largest positive wide value and flagged.
// Assumes SRC_W >= 2; purely combinational.
module sqdmal_dbl_mul #(
    parameter int SRC_W = 16
) (
    input  logic signed [SRC_W-1:0]   op_a,
    input  logic signed [SRC_W-1:0]   op_b,
    output logic signed [2*SRC_W-1:0] dbl_prod,
    output logic                      forced
);
    localparam int WIDE_W = 2 * SRC_W;
    localparam logic [SRC_W-1:0]  NARROW_MIN = {1'b1, {(SRC_W-1){1'b0}}};
    localparam logic [SRC_W-1:0]  NARROW_HALF = {2'b11, {(SRC_W-2){1'b0}}};
    localparam logic [WIDE_W-1:0] WIDE_MAX = {1'b0, {(WIDE_W-1){1'b1}}};

    logic signed [WIDE_W-1:0] raw_prod;
    logic a_min, b_min, a_half, b_half;

    // Exact signed product at double width.
    assign raw_prod = WIDE_W'(op_a) * WIDE_W'(op_b);

    // Match the operands against the fixed extreme-pair table.
    always_comb begin
        a_min  = (op_a == NARROW_MIN);
        b_min  = (op_b == NARROW_MIN);
        a_half = (op_a == NARROW_HALF);
        b_half = (op_b == NARROW_HALF);
        forced = (a_min && b_min) || (a_min && b_half) || (a_half && b_min);
    end

    // Select the forced value or the doubled product.
    always_comb begin
        if (forced) dbl_prod = WIDE_MAX;
        else        dbl_prod = raw_prod <<< 1;
    end
endmodule

// File: rtl/sqdmal_acc_sat.sv
// Module: sqdmal_acc_sat
// Adds the doubled product to, or subtracts it from, one wide accumulator
// lane. Overflow is found from operand and result signs; on overflow the
// result clamps to the wide extreme matching the accumulator's sign.
// Assumes two's-complement operands; purely combinational.
module sqdmal_acc_sat
    import sqdmal_pkg::*;
#(
    parameter int WIDE_W = 32
) (
    input  logic signed [WIDE_W-1:0] acc_lane,
    input  logic signed [WIDE_W-1:0] addend,
    input  acc_op_e                  op,
    output logic signed [WIDE_W-1:0] result,
    output logic                     ovf
);
    localparam logic [WIDE_W-1:0] WIDE_MAX = {1'b0, {(WIDE_W-1){1'b1}}};

    logic signed [WIDE_W-1:0] raw_sum;
    logic signed [WIDE_W-1:0] neg_addend;
    logic eff_sign;
    logic acc_sign;

    // Wrapping add or subtract and the sign of the effective addend.
    always_comb begin
        neg_addend = -addend;
        acc_sign   = acc_lane[WIDE_W-1];
        if (op == ACC_SUB) begin
            raw_sum  = acc_lane - addend;
            eff_sign = neg_addend[WIDE_W-1];
        end else begin
            raw_sum  = acc_lane + addend;
            eff_sign = addend[WIDE_W-1];
        end
    end

    // Sign-based overflow detection and clamping.
    always_comb begin
        ovf = (acc_sign == eff_sign) && (raw_sum[WIDE_W-1] != acc_sign);
        if (ovf) result = acc_sign ? ~WIDE_MAX : WIDE_MAX;
        else     result = raw_sum;
    end
endmodule

// File: rtl/sqdmal_top.sv
// Module: sqdmal_top
// Lane-parallel saturating doubling multiply-accumulate (long). Each lane
// doubles a narrow signed product into a wide value and accumulates it
// with saturation. Results are registered on issue; a sticky flag gathers
// every lane saturation event until reset.
// Assumes SRC_W is 16 or 32; synchronous active-low reset.
module sqdmal_top
    import sqdmal_pkg::*;
#(
    parameter int LANES = 4,
    parameter int SRC_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       issue,
    input  logic                       op_sub,
    input  logic [LANES*SRC_W-1:0]     src_a,
    input  logic [LANES*SRC_W-1:0]     src_b,
    input  logic [LANES*2*SRC_W-1:0]   acc_in,
    output logic [LANES*2*SRC_W-1:0]   acc_out,
    output logic                       sat_flag
);
    localparam int WIDE_W    = 2 * SRC_W;
    localparam int ACC_BUS_W = LANES * WIDE_W;

    acc_op_e                lane_op;
    logic [LANES-1:0]       lane_sat;
    logic [ACC_BUS_W-1:0]   next_acc;

    // Decode the operation select once for all lanes.
    assign lane_op = op_sub ? ACC_SUB : ACC_ADD;

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        logic signed [WIDE_W-1:0] dbl_prod;
        logic signed [WIDE_W-1:0] lane_res;
        logic                     forced;
        logic                     ovf;

        sqdmal_dbl_mul #(.SRC_W(SRC_W)) u_mul (
            .op_a     (src_a[gi*SRC_W +: SRC_W]),
            .op_b     (src_b[gi*SRC_W +: SRC_W]),
            .dbl_prod (dbl_prod),
            .forced   (forced)
        );

        sqdmal_acc_sat #(.WIDE_W(WIDE_W)) u_acc (
            .acc_lane (acc_in[gi*WIDE_W +: WIDE_W]),
            .addend   (dbl_prod),
            .op       (lane_op),
            .result   (lane_res),
            .ovf      (ovf)
        );

        assign next_acc[gi*WIDE_W +: WIDE_W] = lane_res;
        assign lane_sat[gi] = forced | ovf;
    end

    // Register results on issue and accumulate the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_out  <= '0;
            sat_flag <= 1'b0;
        end else if (issue) begin
            acc_out  <= next_acc;
            sat_flag <= sat_flag | (|lane_sat);
        end
    end
endmodule

// File: rtl/sqdmal_chk.sv
// Module: sqdmal_chk
// Assertion checker for sqdmal_top, attached with a bind statement below.
// Observes ports plus the per-lane event vector of the top module.
module sqdmal_chk #(
    parameter int LANES = 4,
    parameter int SRC_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     issue,
    input logic                     op_sub,
    input logic [LANES*SRC_W-1:0]   src_a,
    input logic [LANES*SRC_W-1:0]   src_b,
    input logic [LANES*2*SRC_W-1:0] acc_in,
    input logic [LANES*2*SRC_W-1:0] acc_out,
    input logic                     sat_flag,
    input logic [LANES-1:0]         lane_sat
);
    localparam int WIDE_W = 2 * SRC_W;
    localparam logic [SRC_W-1:0]  NMIN = {1'b1, {(SRC_W-1){1'b0}}};
    localparam logic [WIDE_W-1:0] WMAX = {1'b0, {(WIDE_W-1){1'b1}}};

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sat_flag |=> sat_flag); // R8

    AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (|lane_sat)) |=> sat_flag); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> ($stable(acc_out) && $stable(sat_flag))); // R9

    AST_FORCED_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !op_sub && src_a[SRC_W-1:0] == NMIN && src_b[SRC_W-1:0] == NMIN
         && acc_in[WIDE_W-1:0] == '0) |=> (acc_out[WIDE_W-1:0] == WMAX)); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && src_a[SRC_W-1:0] == '0)
        |=> (acc_out[WIDE_W-1:0] == $past(acc_in[WIDE_W-1:0]))); // R4

    AST_ZERO_LANE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && src_a[SRC_W-1:0] == '0) |-> !lane_sat[0]); // R1
endmodule

bind sqdmal_top sqdmal_chk #(.LANES(LANES), .SRC_W(SRC_W)) u_sqdmal_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (issue),
    .op_sub   (op_sub),
    .src_a    (src_a),
    .src_b    (src_b),
    .acc_in   (acc_in),
    .acc_out  (acc_out),
    .sat_flag (sat_flag),
    .lane_sat (lane_sat)
);

// File: tb/test_sqdmal_top.sv
// Bench for sqdmal_top at LANES=4, SRC_W=16: directed corners plus biased
// random vectors, checked against a range-based reference model.
module test_sqdmal_top;
    localparam int LANES = 4;
    localparam int SRC_W = 16;
    localparam int WIDE_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic issue = 1'b0;
    logic op_sub = 1'b0;
    logic [LANES*SRC_W-1:0]  src_a = '0;
    logic [LANES*SRC_W-1:0]  src_b = '0;
    logic [LANES*WIDE_W-1:0] acc_in = '0;
    logic [LANES*WIDE_W-1:0] acc_out;
    logic sat_flag;

    int n_checks = 0;
    int n_fail = 0;
    logic [LANES*WIDE_W-1:0] exp_acc = '0;
    bit exp_sat = 1'b0;

    always #10 clk = ~clk;

    sqdmal_top #(.LANES(LANES), .SRC_W(SRC_W)) i_sqdmal_top (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op_sub(op_sub),
        .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
        .acc_out(acc_out), .sat_flag(sat_flag)
    );

    // Reference: exact product, forced pairs, then clamp to wide range.
    function automatic void lane_model(input shortint a, input shortint b,
                                       input int acc, input bit sub,
                                       output int res, output bit ev);
        longint d, s;
        ev = 1'b0;
        if ((a == -32768 && b == -32768) || (a == -32768 && b == -16384) ||
            (a == -16384 && b == -32768)) begin
            d = 64'sd2147483647;
            ev = 1'b1;
        end else begin
            d = 2 * longint'(a) * longint'(b);
        end
        s = sub ? longint'(acc) - d : longint'(acc) + d;
        if (s > 64'sd2147483647) begin s = 64'sd2147483647; ev = 1'b1; end
        if (s < -64'sd2147483648) begin s = -64'sd2147483648; ev = 1'b1; end
        res = int'(s);
    endfunction

    task automatic check_outputs(input string tag);
        for (int i = 0; i < LANES; i++) begin
            n_checks++;
            if (acc_out[i*WIDE_W +: WIDE_W] !== exp_acc[i*WIDE_W +: WIDE_W]) begin
                n_fail++;
                $display("FAIL %s lane %0d acc_out=%h expected=%h", tag, i,
                         acc_out[i*WIDE_W +: WIDE_W], exp_acc[i*WIDE_W +: WIDE_W]);
            end
        end
        n_checks++;
        if (sat_flag !== exp_sat) begin
            n_fail++;
            $display("FAIL %s sat_flag=%b expected=%b", tag, sat_flag, exp_sat);
        end
    endtask

    // Drive one operation at a falling edge, check one cycle later.
    task automatic apply(input logic [LANES*SRC_W-1:0] a,
                         input logic [LANES*SRC_W-1:0] b,
                         input logic [LANES*WIDE_W-1:0] acc,
                         input bit sub, input string tag);
        int r;
        bit ev;
        @(negedge clk);
        src_a = a; src_b = b; acc_in = acc; op_sub = sub; issue = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            lane_model(shortint'(a[i*SRC_W +: SRC_W]), shortint'(b[i*SRC_W +: SRC_W]),
                       int'(acc[i*WIDE_W +: WIDE_W]), sub, r, ev);
            exp_acc[i*WIDE_W +: WIDE_W] = r;
            exp_sat = exp_sat | ev;
        end
        @(negedge clk);
        issue = 1'b0;
        check_outputs(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; issue = 1'b0;
        repeat (2) @(negedge clk);
        exp_acc = '0; exp_sat = 1'b0;
        check_outputs("R10 reset");
        rst_n = 1'b1;
    endtask

    function automatic logic [SRC_W-1:0] pick_narrow();
        case ($urandom % 8)
            0: return 16'h8000;
            1: return 16'hC000;
            2: return 16'h7FFF;
            default: return 16'($urandom);
        endcase
    endfunction

    function automatic logic [WIDE_W-1:0] pick_wide();
        case ($urandom % 6)
            0: return 32'h7FFF_FFFF;
            1: return 32'h8000_0000;
            2: return 32'h0000_0000;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        do_reset();
        // R1 R4 R8: benign products, no event, flag stays clear.
        apply({16'd3, 16'hFFFE, 16'd100, 16'd7}, {16'd5, 16'd9, 16'hFF9C, 16'd0},
              {32'd1, 32'd2, 32'hFFFF_FFF0, 32'd55}, 1'b0, "R1 R4 plain add");
        apply({16'd12, 16'd1, 16'h7FFF, 16'd2}, {16'd3, 16'h8000, 16'd2, 16'd2},
              {32'd10, 32'd0, 32'd0, 32'd8}, 1'b1, "R6 R8 plain sub");
        // R2: min*min forced, lane 1 only; R7 other lanes unaffected.
        apply({16'd1, 16'd2, 16'h8000, 16'd4}, {16'd1, 16'd2, 16'h8000, 16'd4},
              {32'd0, 32'd0, 32'd0, 32'd0}, 1'b0, "R2 R7 min*min");
        // R8: flag stays set with benign operation.
        apply('0, '0, {32'd5, 32'd6, 32'd7, 32'd8}, 1'b0, "R8 sticky");
        // R3: min*half both orders, then half*half not forced.
        apply({16'h8000, 16'hC000, 16'hC000, 16'h0}, {16'hC000, 16'h8000, 16'hC000, 16'h0},
              '0, 1'b0, "R3 half pairs");
        do_reset();
        // R5: positive and negative add overflow.
        apply({16'h7FFF, 16'h7FFF, 16'd1, 16'd1}, {16'h7FFF, 16'h8001, 16'd1, 16'd1},
              {32'h7FFF_0000, 32'h8000_0000, 32'h7FFF_FFFE, 32'h7FFF_FFFD}, 1'b0,
              "R5 add overflow");
        do_reset();
        // R6: subtract overflow both signs.
        apply({16'h7FFF, 16'h7FFF, 16'd1, 16'd0}, {16'h7FFF, 16'h8001, 16'd1, 16'd0},
              {32'h8000_0000, 32'h7FFF_0000, 32'h8000_0001, 32'h8000_0000}, 1'b1,
              "R6 sub overflow");
        // R9: idle cycles with changed inputs leave outputs unchanged.
        @(negedge clk);
        src_a = '1; src_b = '1; acc_in = '1; op_sub = 1'b0; issue = 1'b0;
        repeat (3) @(negedge clk);
        check_outputs("R9 idle hold");
        // Biased random vectors covering R1..R8.
        for (int n = 0; n < 400; n++) begin
            logic [LANES*SRC_W-1:0] ra, rb;
            logic [LANES*WIDE_W-1:0] rc;
            for (int i = 0; i < LANES; i++) begin
                ra[i*SRC_W +: SRC_W] = pick_narrow();
                rb[i*SRC_W +: SRC_W] = pick_narrow();
                rc[i*WIDE_W +: WIDE_W] = pick_wide();
            end
            if (n % 100 == 0) do_reset();
            apply(ra, rb, rc, 1'($urandom % 2), "R1-random R7");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule